// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. The distributor hands it a level-sensitive pending vector of the interrupts routed to this CPU, together with a priority value for each of them. The block tracks which of those interrupts the CPU is currently servicing, picks the most urgent one that is still waiting, and raises a single request line towards the CPU.

Software talks to it through a small 32-bit register bus with four word slots: a control word, a priority threshold, an acknowledge slot and an end-of-interrupt slot. Reading the acknowledge slot hands out the ID of the selected interrupt and moves it to the active state; writing that ID to the end-of-interrupt slot returns it to inactive. When nothing qualifies, the acknowledge read yields the reserved spurious ID 1023, which software recognises as "nothing to do".

Top module: `cpu_ack_if`

## Requirements
- R1: After reset the control enable bit is 0, the priority threshold reads 0xF0, no interrupt is active and `irq_o` is low.
- R2: `irq_o` is high exactly when the control enable (bit 0 of slot 0) is 1 and at least one interrupt is pending, not active and has a priority value strictly lower than the threshold.
- R3: Among qualifying interrupts the one with the smallest priority value is selected; on equal priority the smallest ID wins.
- R4: A read of slot 2 (acknowledge) returns the selected ID in `bus_rdata_o[9:0]` with the upper bits zero, in the cycle after the request, and marks that interrupt active.
- R5: When nothing qualifies or the enable bit is 0, an acknowledge read returns 1023 and changes no state.
- R6: An active interrupt is not selected or signalled again until its end-of-interrupt write, even if it stays pending.
- R7: A write to slot 3 (end-of-interrupt) with `bus_wdata_i[9:0]` equal to an active ID returns that interrupt to inactive.
- R8: An end-of-interrupt write naming an ID that is not active, or one at or above the number of inputs, is ignored.
- R9: Slot 0 bit 0 and slot 1 bits [7:0] are writable and read back, with read data one cycle after the request; slot numbers come from `bus_idx_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pend_i | input | NUM_IRQ | Pending levels from the distributor |
| prio_i | input | NUM_IRQ*PRIO_W | Priority value per interrupt, ID 0 in the low bits |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_idx_i | input | 2 | Register slot: 0 control, 1 threshold, 2 acknowledge, 3 end-of-interrupt |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with eight interrupt inputs and 8-bit priorities, so every ID, including the highest one, can be driven with a hand-chosen priority and the tie-break can be exercised at both ends of the vector. With only eight inputs, end-of-interrupt IDs from 8 upward fall outside the array, which brings the out-of-range ignore rule within reach alongside the inactive-ID case. Threshold values of 0x00, 0x01, 0x80, 0x81, 0xF0 and 0xFF place priorities exactly on and beside the strict-less-than boundary.

// File: rtl/cpu_ack_if_pkg.sv
package cpu_ack_if_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_THRSH = 2'd1,
    SLOT_ACK   = 2'd2,
    SLOT_EOI   = 2'd3
  } slot_e;
endpackage

// File: rtl/cpu_ack_pick.sv
module cpu_ack_pick #(
  parameter int unsigned NUM_IRQ = 16,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_IRQ-1:0]        elig_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // Strict less-than keeps the earlier (lower) ID on equal priority.
  always_comb begin
    found_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int i = 0; i < int'(NUM_IRQ); i++) begin
      if (elig_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
        found_o   = 1'b1;
        idx_o     = IDX_W'(i);
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cpu_ack_state.sv
module cpu_ack_state #(
  parameter int unsigned NUM_IRQ = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_IRQ-1:0] active_o
);
  logic [NUM_IRQ-1:0] active_q, active_d;
  logic               upd_en;

  assign upd_en = set_en_i | clr_en_i;

  always_comb begin
    active_d = active_q;
    if (set_en_i) active_d[set_idx_i] = 1'b1;
    if (clr_en_i) active_d[clr_idx_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= '0;
    else if (upd_en) active_q <= active_d;
  end

  assign active_o = active_q;

  // R4: an acknowledged interrupt is active in the next cycle
  p_ack_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |=> active_q[$past(set_idx_i)]);

  // R6: only an inactive interrupt may be acknowledged
  p_set_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |-> !active_q[set_idx_i]);

  // R7: end-of-interrupt on an active ID leaves it inactive
  p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && active_q[clr_idx_i]) |=> !active_q[$past(clr_idx_i)]);

  // R8: without a set or clear nothing moves
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en_i && !clr_en_i) |=> $stable(active_q));
endmodule

// File: rtl/cpu_ack_if.sv
module cpu_ack_if
  import cpu_ack_if_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic                      bus_req_i,
  input  logic                      bus_we_i,
  input  logic [1:0]                bus_idx_i,
  input  logic [31:0]               bus_wdata_i,
  output logic [31:0]               bus_rdata_o,
  output logic                      irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] NUM_ID = ID_W'(NUM_IRQ);
  localparam logic [PRIO_W-1:0] THRSH_RST = PRIO_W'(8'hF0);

  logic               en_q, en_d;
  logic [PRIO_W-1:0]  thrsh_q, thrsh_d;
  logic [31:0]        rdata_q, rdata_d;
  logic               ctrl_we, thrsh_we, rd_en;

  logic [NUM_IRQ-1:0] active, under_thrsh, elig;
  logic               found;
  logic [IDX_W-1:0]   best_idx;
  logic               ack_rd, ack_hit, eoi_wr;
  logic [ID_W-1:0]    eoi_id;

  // Threshold compare per input
  for (genvar g = 0; g < int'(NUM_IRQ); g++) begin : g_thrsh
    assign under_thrsh[g] = prio_i[g*PRIO_W +: PRIO_W] < thrsh_q;
  end

  assign elig = pend_i & ~active & under_thrsh;

  cpu_ack_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) pick_i (
    .elig_i  (elig),
    .prio_i  (prio_i),
    .found_o (found),
    .idx_o   (best_idx)
  );

  // Bus decode
  assign rd_en    = bus_req_i & ~bus_we_i;
  assign ctrl_we  = bus_req_i & bus_we_i & (bus_idx_i == SLOT_CTRL);
  assign thrsh_we = bus_req_i & bus_we_i & (bus_idx_i == SLOT_THRSH);
  assign ack_rd   = rd_en & (bus_idx_i == SLOT_ACK);
  assign ack_hit  = ack_rd & en_q & found;
  assign eoi_id   = bus_wdata_i[ID_W-1:0];
  assign eoi_wr   = bus_req_i & bus_we_i & (bus_idx_i == SLOT_EOI) & (eoi_id < NUM_ID);

  cpu_ack_state #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) state_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en_i  (ack_hit),
    .set_idx_i (best_idx),
    .clr_en_i  (eoi_wr),
    .clr_idx_i (eoi_id[IDX_W-1:0]),
    .active_o  (active)
  );

  // Next-state
  always_comb begin
    en_d    = bus_wdata_i[0];
    thrsh_d = bus_wdata_i[PRIO_W-1:0];
    unique case (bus_idx_i)
      SLOT_CTRL:  rdata_d = {31'd0, en_q};
      SLOT_THRSH: rdata_d = {{(32-PRIO_W){1'b0}}, thrsh_q};
      SLOT_ACK:   rdata_d = ack_hit ? {{(32-IDX_W){1'b0}}, best_idx}
                                    : {{(32-ID_W){1'b0}}, SPURIOUS_ID};
      default:    rdata_d = 32'd0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      thrsh_q <= THRSH_RST;
      rdata_q <= 32'd0;
    end else begin
      if (ctrl_we)  en_q    <= en_d;
      if (thrsh_we) thrsh_q <= thrsh_d;
      if (rd_en)    rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = en_q & found;

  // R3: the selected interrupt is one that qualifies
  p_pick_elig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend_i[best_idx] && under_thrsh[best_idx]));

  // R6: an active interrupt is never the selected one
  p_active_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !active[best_idx]);

  // R4: a granted acknowledge returns the selected index next cycle
  p_ack_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> bus_rdata_o == {{(32-IDX_W){1'b0}}, $past(best_idx)});

  // R5: a spurious acknowledge returns 1023 and leaves state alone
  p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !ack_hit) |=> (bus_rdata_o == 32'd1023 && $stable(active)));
endmodule

// File: tb/cpu_ack_if_tb_top.sv
module cpu_ack_if_tb_top;
  localparam int  N       = 8;
  localparam int  PW      = 8;
  localparam time CLK_PER = 10ns;
  localparam int  NV      = 12;

  // {pending, threshold, expected id}
  localparam logic [25:0] VEC [NV] = '{
    {8'h01, 8'hF0, 10'd0},
    {8'h06, 8'hF0, 10'd1},
    {8'h08, 8'hF0, 10'd1023},
    {8'h50, 8'hF0, 10'd4},
    {8'hFF, 8'hF0, 10'd7},
    {8'h7F, 8'hF0, 10'd4},
    {8'h21, 8'h80, 10'd1023},
    {8'h23, 8'h81, 10'd1},
    {8'h08, 8'hFF, 10'd3},
    {8'h00, 8'hF0, 10'd1023},
    {8'h80, 8'h00, 10'd1023},
    {8'h80, 8'h01, 10'd7}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   pend;
  logic [N*PW-1:0] prio;
  logic           req, we;
  logic [1:0]     idx;
  logic [31:0]    wdata, rdata;
  logic           irq;
  int             total = 0;
  int             bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  cpu_ack_if #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio),
    .bus_req_i(req), .bus_we_i(we), .bus_idx_i(idx),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Inputs change on the falling edge; read data sampled one falling edge later.
  task automatic bus_rd(input logic [1:0] s, output logic [31:0] d);
    req = 1'b1; we = 1'b0; idx = s;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
    req = 1'b1; we = 1'b1; idx = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; idx = 2'd0; wdata = '0; pend = '0;
    // priorities: id0 80, id1 40, id2 40, id3 F0, id4 10, id5 EF, id6 10, id7 00
    prio = {8'h00, 8'h10, 8'hEF, 8'h10, 8'hF0, 8'h40, 8'h40, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    bus_rd(2'd0, d); chk(d == 32'd0, "R1 ctrl", d, 0);
    bus_rd(2'd1, d); chk(d == 32'hF0, "R1 threshold", d, 32'hF0);

    // R9 register read-back
    bus_wr(2'd1, 32'h0000_0A5C);
    bus_rd(2'd1, d); chk(d == 32'h5C, "R9 threshold", d, 32'h5C);
    bus_wr(2'd1, 32'hF0);

    // R5 disabled: pending but no signal, spurious ack, no state change
    pend = 8'h01;
    @(negedge clk);
    chk(irq == 1'b0, "R2 disabled irq", 32'(irq), 0);
    bus_rd(2'd2, d); chk(d == 32'd1023, "R5 disabled ack", d, 1023);
    bus_wr(2'd0, 32'h1);
    bus_rd(2'd0, d); chk(d == 32'd1, "R9 ctrl", d, 1);
    chk(irq == 1'b1, "R5 not taken while disabled", 32'(irq), 1);
    bus_rd(2'd2, d); chk(d == 32'd0, "R4 ack after enable", d, 0);
    bus_wr(2'd3, 32'd0);
    pend = '0;
    @(negedge clk);

    // R2 R3 R4 table walk
    foreach (VEC[k]) begin
      bus_wr(2'd1, {24'd0, VEC[k][17:10]});
      pend = VEC[k][25:18];
      @(negedge clk);
      chk(irq == (VEC[k][9:0] != 10'd1023), $sformatf("R2 vec%0d irq", k), 32'(irq),
          32'(VEC[k][9:0] != 10'd1023));
      bus_rd(2'd2, d);
      chk(d == {22'd0, VEC[k][9:0]}, $sformatf("R3 vec%0d id", k), d, {22'd0, VEC[k][9:0]});
      if (VEC[k][9:0] != 10'd1023) bus_wr(2'd3, {22'd0, VEC[k][9:0]});
      pend = '0;
      @(negedge clk);
    end

    // R6 active not re-presented
    bus_wr(2'd1, 32'hF0);
    pend = 8'h03;
    @(negedge clk);
    bus_rd(2'd2, d); chk(d == 32'd1, "R6 first ack", d, 1);
    chk(irq == 1'b1, "R6 irq with id0 left", 32'(irq), 1);
    bus_rd(2'd2, d); chk(d == 32'd0, "R6 second ack", d, 0);
    chk(irq == 1'b0, "R6 irq all active", 32'(irq), 0);
    bus_rd(2'd2, d); chk(d == 32'd1023, "R6 third ack", d, 1023);

    // R8 ignored EOIs
    bus_wr(2'd3, 32'd5);
    bus_wr(2'd3, 32'd200);
    bus_wr(2'd3, 32'd9);
    chk(irq == 1'b0, "R8 irq after bad eoi", 32'(irq), 0);
    bus_rd(2'd2, d); chk(d == 32'd1023, "R8 ack after bad eoi", d, 1023);

    // R7 EOI releases
    bus_wr(2'd3, 32'd1);
    chk(irq == 1'b1, "R7 irq after eoi", 32'(irq), 1);
    bus_rd(2'd2, d); chk(d == 32'd1, "R7 ack after eoi", d, 1);
    bus_wr(2'd3, 32'd1);
    bus_wr(2'd3, 32'd0);
    pend = 8'h01;
    @(negedge clk);
    bus_rd(2'd2, d); chk(d == 32'd0, "R7 id0 released", d, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule